// File: doc/BRIEF.md
# Scaler Filter Coefficient Loader

This block sits between a register bus and the two coefficient memories of a polyphase scaler. One memory serves the horizontal filter and one the vertical filter. Software first writes a pointer register. That write picks a start index and chooses which memory or memories receive data. Software then streams coefficient words into a data register. Each accepted word is stored at the current index in every chosen memory, and the index then moves on by one. A complete set of 96 coefficients can therefore be loaded after a single pointer write. When both memories are chosen, one stream fills both of them with identical contents.

The filter datapath reads the memories through two independent read ports, one for each direction. Each read port takes an index and returns the stored coefficient one clock later. Coefficients are 14-bit two's complement numbers: 0x1000 is the unity centre tap, and codes with bit 13 set are negative. The block does not interpret these values. It only stores them.

Top module: `coef_table_loader`

## Requirements
- R1: A bus write at offset 0x10 loads the pointer register. Bits [6:0] give the start index, and a start value above 95 is clamped to 95. Bit 8 chooses the vertical memory and bit 9 chooses the horizontal memory. Each such write replaces the earlier choice and clears the end-of-table condition.
- R2: A bus write at offset 0x14 is a data write. It stores bits [13:0] of the bus word at the current index in every chosen memory. Bus bits above 13 are discarded.
- R3: When both memory choices are set, one data write stores the same value at the same index in both memories. When neither is set, nothing is stored, but the index still advances.
- R4: After each accepted data write, the index rises by one. Writing 96 words after one pointer write with start 0 fills indices 0 to 95 in order.
- R5: After a store at index 95, the index holds at 95 and any further data write is dropped. Such a dropped write sets the overflow output. The overflow output stays at 1 until reset, and later pointer writes do not clear it.
- R6: Each read port returns the content at its index one clock after the index is presented. An index of 96 or higher returns 0.
- R7: If a read port's index equals the index being written in its memory in the same cycle, the read returns the newly written value.
- R8: Bus writes at any offset other than 0x10 and 0x14 change no stored content, index, choice or flag.
- R9: After reset, every stored entry is 0, both read outputs are 0, the overflow output is 0, no memory is chosen and the index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Bus write strobe |
| cfg_ofs | input | 8 | Byte offset of the bus write |
| cfg_wdata | input | 32 | Bus write data |
| hrd_idx | input | 7 | Horizontal read index |
| hrd_data | output | 14 | Horizontal coefficient, one cycle after the index |
| vrd_idx | input | 7 | Vertical read index |
| vrd_data | output | 14 | Vertical coefficient, one cycle after the index |
| ovf_flag | output | 1 | Sticky flag for data written past the last index |

## Verification
The hardest state to reach from the ports is the end of the table. Reaching it takes a full run of accepted writes, or a pointer write whose start value must be clamped. Only after that is a dropped write possible, and the flag it sets must survive later pointer writes. The stimulus gets there by streaming a complete 96-word set, and also by using a start index of 127 with the horizontal memory chosen. It then keeps writing past the end and reloads the pointer. A reference model of both memories is compared on every clock while both read ports sweep all indices, including out-of-range ones. Other cycles place the read index exactly on the index being written, which exercises the bypass path.

// File: rtl/coef_pkg.sv
package coef_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PTR  = 2'd1,
    OP_DATA = 2'd2
  } bus_op_t;

  typedef struct packed {
    logic h;
    logic v;
  } bank_sel_t;
endpackage

// File: rtl/coef_bus_decode.sv
module coef_bus_decode #(
  parameter int OFS_W    = 8,
  parameter int PTR_OFS  = 'h10,
  parameter int DATA_OFS = 'h14
) (
  input  logic               wr,
  input  logic [OFS_W-1:0]   ofs,
  output coef_pkg::bus_op_t  op
);
  localparam logic [OFS_W-1:0] PTR_O  = OFS_W'(PTR_OFS);
  localparam logic [OFS_W-1:0] DATA_O = OFS_W'(DATA_OFS);

  always_comb begin
    op = coef_pkg::OP_NONE;
    if (wr && ofs == PTR_O)  op = coef_pkg::OP_PTR;
    if (wr && ofs == DATA_O) op = coef_pkg::OP_DATA;
  end
endmodule

// File: rtl/coef_ptr_ctrl.sv
module coef_ptr_ctrl #(
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  coef_pkg::bus_op_t    op,
  input  logic [AW-1:0]        start_idx,
  input  logic                 sel_v_in,
  input  logic                 sel_h_in,
  output logic [AW-1:0]        ptr,
  output logic                 wr_h,
  output logic                 wr_v,
  output logic                 ovf
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] clamp_start(input logic [AW-1:0] s);
    return (s > LAST) ? LAST : s;
  endfunction

  coef_pkg::bank_sel_t sel;
  logic full;
  logic ptr_ev, data_ev, store_ev, drop_ev;

  assign ptr_ev   = (op == coef_pkg::OP_PTR);
  assign data_ev  = (op == coef_pkg::OP_DATA);
  assign store_ev = data_ev && !full;
  assign drop_ev  = data_ev && full;
  assign wr_h     = store_ev && sel.h;
  assign wr_v     = store_ev && sel.v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      sel  <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (ptr_ev) begin
        ptr   <= clamp_start(start_idx);
        sel.h <= sel_h_in;
        sel.v <= sel_v_in;
        full  <= 1'b0;
      end else if (store_ev) begin
        if (ptr == LAST) full <= 1'b1;
        else             ptr  <= ptr + 1'b1;
      end
      if (drop_ev) ovf <= 1'b1;
    end
  end

  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ev && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r5_no_store_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(wr_h || wr_v));
  a_r1_ptr_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ev |=> (!full && ptr <= LAST));
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int DEPTH = 96,
  parameter int AW    = 7,
  parameter int CW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] mem [DEPTH];
  logic hit;

  assign hit = we && (waddr == ridx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (hit)                      rdata <= wdata;
      else if (int'(ridx) < DEPTH)  rdata <= mem[ridx];
      else                          rdata <= '0;
    end
  end

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rdata == $past(wdata));
  a_r2_stored: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
  a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ridx) >= DEPTH) |=> rdata == '0);
endmodule

// File: rtl/coef_table_loader.sv
module coef_table_loader #(
  parameter int DEPTH    = 96,
  parameter int AW       = 7,
  parameter int CW       = 14,
  parameter int BUS_W    = 32,
  parameter int OFS_W    = 8,
  parameter int PTR_OFS  = 'h10,
  parameter int DATA_OFS = 'h14,
  parameter int VSEL_BIT = 8,
  parameter int HSEL_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [OFS_W-1:0] cfg_ofs,
  input  logic [BUS_W-1:0] cfg_wdata,
  input  logic [AW-1:0]    hrd_idx,
  output logic [CW-1:0]    hrd_data,
  input  logic [AW-1:0]    vrd_idx,
  output logic [CW-1:0]    vrd_data,
  output logic             ovf_flag
);
  localparam int NBANK = 2;

  function automatic logic [CW-1:0] coef_mask(input logic [BUS_W-1:0] w);
    return w[CW-1:0];
  endfunction

  coef_pkg::bus_op_t op;
  logic [AW-1:0] ptr;
  logic wr_h, wr_v;
  logic [NBANK-1:0] bank_we;
  logic [AW-1:0] bank_ridx [NBANK];
  logic [CW-1:0] bank_rdata [NBANK];
  logic unused_bits;

  assign unused_bits = ^cfg_wdata[BUS_W-1:CW];

  coef_bus_decode #(.OFS_W(OFS_W), .PTR_OFS(PTR_OFS), .DATA_OFS(DATA_OFS)) dec_i (
    .wr(cfg_wr), .ofs(cfg_ofs), .op(op)
  );

  coef_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctl_i (
    .clk(clk), .rst_n(rst_n), .op(op),
    .start_idx(cfg_wdata[AW-1:0]),
    .sel_v_in(cfg_wdata[VSEL_BIT]), .sel_h_in(cfg_wdata[HSEL_BIT]),
    .ptr(ptr), .wr_h(wr_h), .wr_v(wr_v), .ovf(ovf_flag)
  );

  assign bank_we      = {wr_v, wr_h};
  assign bank_ridx[0] = hrd_idx;
  assign bank_ridx[1] = vrd_idx;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    coef_bank #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) bank_i (
      .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .waddr(ptr),
      .wdata(coef_mask(cfg_wdata)), .ridx(bank_ridx[b]), .rdata(bank_rdata[b])
    );
  end

  assign hrd_data = bank_rdata[0];
  assign vrd_data = bank_rdata[1];

  a_r3_dual_same_index: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_h && wr_v) |=> (g_bank[0].bank_i.mem[$past(ptr)] == g_bank[1].bank_i.mem[$past(ptr)]));
endmodule

// File: tb/coef_table_loader_tb_top.sv
module coef_table_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic [6:0] hrd_idx = '0, vrd_idx = '0;
  logic [13:0] hrd_data, vrd_data;
  logic ovf_flag;

  always #10 clk = ~clk;

  coef_table_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs),
    .cfg_wdata(cfg_wdata), .hrd_idx(hrd_idx), .hrd_data(hrd_data),
    .vrd_idx(vrd_idx), .vrd_data(vrd_data), .ovf_flag(ovf_flag)
  );

  int n_checks = 0, n_fail = 0;
  string cur_req = "R9";
  bit chk_on = 0;

  // behavioural reference
  int m_h [96];
  int m_v [96];
  int m_ptr = 0, e_h = 0, e_v = 0;
  bit m_full = 0, m_selh = 0, m_selv = 0, m_ovf = 0;

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_h[i]) begin m_h[i] = 0; m_v[i] = 0; end
      m_ptr = 0; m_full = 0; m_selh = 0; m_selv = 0; m_ovf = 0; e_h = 0; e_v = 0;
    end else begin
      int nh, nv, d, s;
      nh = (hrd_idx < 96) ? m_h[hrd_idx] : 0;
      nv = (vrd_idx < 96) ? m_v[vrd_idx] : 0;
      if (cfg_wr && cfg_ofs == 8'h14) begin
        if (m_full) m_ovf = 1;
        else begin
          d = int'(cfg_wdata) & 'h3fff;
          if (m_selh) begin m_h[m_ptr] = d; if (m_ptr == hrd_idx) nh = d; end
          if (m_selv) begin m_v[m_ptr] = d; if (m_ptr == vrd_idx) nv = d; end
          if (m_ptr == 95) m_full = 1; else m_ptr++;
        end
      end else if (cfg_wr && cfg_ofs == 8'h10) begin
        s = int'(cfg_wdata) & 127;
        m_ptr = (s > 95) ? 95 : s;
        m_selv = cfg_wdata[8];
        m_selh = cfg_wdata[9];
        m_full = 0;
      end
      e_h = nh; e_v = nv;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(cur_req, hrd_data, e_h, "hrd_data");
      check(cur_req, vrd_data, e_v, "vrd_data");
      check(cur_req, ovf_flag, m_ovf, "ovf_flag");
    end
  end

  // tasks start just after a falling edge
  task automatic bus(input logic [7:0] o, input logic [31:0] d);
    cfg_wr = 1; cfg_ofs = o; cfg_wdata = d;
    @(negedge clk);
  endtask
  task automatic idle();
    cfg_wr = 0; @(negedge clk);
  endtask
  task automatic sweep();
    cfg_wr = 0;
    for (int i = 0; i < 128; i++) begin
      hrd_idx = 7'(i); vrd_idx = 7'(127 - i);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", hrd_data, 0, "reset hrd");
    check("R9", vrd_data, 0, "reset vrd");
    check("R9", ovf_flag, 0, "reset ovf");
    rst_n = 1; chk_on = 1;
    @(negedge clk);
    cur_req = "R9"; sweep();
    // R9: no bank chosen after reset, index 0
    bus(8'h14, 32'h0000_0123); idle();
    cur_req = "R9"; sweep();

    // R4/R2: full vertical set with garbage upper bits
    cur_req = "R4";
    bus(8'h10, 32'h0000_0100);
    for (int i = 0; i < 96; i++) bus(8'h14, 32'hABC0_0000 | 32'((i * 173 + 5) & 'hffff));
    idle(); sweep();
    cur_req = "R2";
    vrd_idx = 3; @(negedge clk); @(negedge clk);
    check("R2", vrd_data, ((3 * 173 + 5) & 'hffff) & 'h3fff, "masked entry 3");

    // R3: both banks, then neither
    cur_req = "R3";
    bus(8'h10, 32'h0000_030A);
    for (int i = 0; i < 5; i++) bus(8'h14, 32'(16'h3FC6 - i));
    bus(8'h10, 32'h0000_0000);
    for (int i = 0; i < 3; i++) bus(8'h14, 32'h1000);
    idle(); sweep();

    // R1 clamp and R5 overflow
    cur_req = "R1";
    bus(8'h10, 32'h0000_027F);
    bus(8'h14, 32'h0000_0777);
    idle();
    hrd_idx = 95; @(negedge clk); @(negedge clk);
    check("R1", hrd_data, 'h777, "clamped start stores at 95");
    cur_req = "R5";
    check("R5", ovf_flag, 0, "no ovf before extra write");
    bus(8'h14, 32'h0000_0111); bus(8'h14, 32'h0000_0222); idle();
    check("R5", ovf_flag, 1, "ovf after extra write");
    bus(8'h10, 32'h0000_0200); idle();
    check("R5", ovf_flag, 1, "ovf survives pointer write");
    sweep();

    // R7: same-cycle write and read
    cur_req = "R7";
    bus(8'h10, 32'h0000_0314);
    hrd_idx = 20; vrd_idx = 20;
    bus(8'h14, 32'h0000_2ABC);
    cfg_wr = 0;
    check("R7", hrd_data, 'h2ABC, "bypass h");
    check("R7", vrd_data, 'h2ABC, "bypass v");
    @(negedge clk);

    // R8: other offsets
    cur_req = "R8";
    bus(8'h18, 32'h0000_0355); bus(8'h0C, 32'h0000_1111); bus(8'h11, 32'h0000_2222);
    idle();
    hrd_idx = 21; @(negedge clk); @(negedge clk);
    check("R8", hrd_data, 0, "entry 21 untouched");
    bus(8'h14, 32'h0000_0042); idle();
    hrd_idx = 21; @(negedge clk); @(negedge clk);
    check("R8", hrd_data, 'h42, "pointer unchanged by stray writes");
    sweep();

    // R6: index changes every cycle, incl out of range
    cur_req = "R6";
    for (int i = 0; i < 200; i++) begin
      hrd_idx = 7'((i * 37) % 128); vrd_idx = 7'((i * 91 + 7) % 128);
      @(negedge clk);
    end
    idle();

    chk_on = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule